// File: doc/BRIEF.md
# Four-Sided Track Switch Box

This block is the 16-bit routing crossbar of one tile in a reconfigurable array. Every side of the tile (side 0 east, side 1 south, side 2 west, side 3 north) has a group of incoming and a group of outgoing word-wide tracks. Each outgoing track has its own configuration entry. The entry names the source of the track: any incoming track on one of the other three sides, the tile core's result word, or nothing. The entry also holds a bit that sends the chosen word through a pipeline register inside the box. Several outgoing tracks may name the same incoming track, which is how a routed net branches inside a tile.

A second, smaller set of selectors taps outgoing tracks of the box and feeds them to the tile core as operand words. The taps are taken after the optional register. Configuration is written one entry per cycle through an address/data write port. The narrow 1-bit track class is handled elsewhere.

With the default parameters there are 4 sides × 4 tracks = 16 outgoing tracks, 16-bit words and 2 core operands. Track index i = side*4 + track, and it occupies bits [i*16 +: 16] of the flat track buses.

Top module: `track_switch_box`

## Requirements
- R1: For an outgoing track i whose register bit is 0, a source code v in 1..16 passes incoming track v-1 to output i in the same cycle, provided (v-1)/4 differs from i/4, which means the source is on another side.
- R2: A source code v in 1..16 whose incoming track lies on the same side as output i ((v-1)/4 == i/4) makes output i drive zero.
- R3: Source code 17 drives the tile core result `coreOut` onto the output. Source code 0 and codes 18..31 drive zero.
- R4: With its register bit set to 1, an output presents the value its selected source had at the previous rising clock edge. The delay is exactly one cycle.
- R5: One incoming track selected by several outputs on different sides appears on all of them at once.
- R6: Operand selector k (address 16+k) with code v in 1..16 places outgoing track v-1 on `coreOps[k*16 +: 16]`, and this includes that track's register delay. Code 0 and codes 17..31 give zero. The register bit of an operand write is ignored.
- R7: After reset every source code, register bit and pipeline register is zero, so all outputs and all operands read zero.
- R8: A write with `cfgWe`=1 to address a (0..15 for outputs, 16..17 for operands) stores `cfgData[4:0]` as the source code and `cfgData[5]` as the register bit. The new setting acts after that clock edge. Writes to addresses 18..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgAddr | input | 5 | Entry address: 0..15 outputs, 16..17 operands |
| cfgData | input | 6 | Bit 5 register enable, bits 4:0 source code |
| inTracks | input | 256 | Incoming tracks, index side*4+track, 16 bits each |
| coreOut | input | 16 | Tile core result word |
| outTracks | output | 256 | Outgoing tracks, same indexing as inTracks |
| coreOps | output | 32 | Operand words to the tile core, 16 bits each |

## Verification
A corrupted source code or register bit shows on the affected output in the very cycle after the faulty write. The output then carries the wrong incoming word, zero, or the core word, and the sweep drives fresh random data every cycle, so the difference cannot stay hidden. A pipeline register that holds a wrong value or misses an update is seen one cycle after its source changes. A broken same-side check appears as a nonzero word where zero belongs. Operand taps copy output tracks, so any output fault also reaches `coreOps` in the same cycle when a tap points at that output.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  localparam int SIDES     = 4;
  localparam int TRACKS    = 4;
  localparam int WIDTH     = 16;
  localparam int OPS       = 2;
  localparam int NOUT      = SIDES * TRACKS;
  localparam int CORE_CODE = NOUT + 1;
  localparam int SEL_W     = $clog2(NOUT + 2);
  localparam int ADDR_W    = $clog2(NOUT + OPS);
  localparam int CFG_W     = SEL_W + 1;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic              wrOut;
    logic              wrOp;
    logic [ADDR_W-1:0] slot;
    logic              regEn;
    sel_t              sel;
  } cfgStrobe_t;
endpackage

// File: rtl/tsb_ctrl.sv
module tsb_ctrl
  import tsb_pkg::*;
(
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CFG_W-1:0]  cfgData,
  output cfgStrobe_t        strobe
);
  always_comb begin
    strobe       = '0;
    strobe.regEn = cfgData[CFG_W-1];
    strobe.sel   = cfgData[SEL_W-1:0];
    if (cfgWe) begin
      if (int'(cfgAddr) < NOUT) begin
        strobe.wrOut = 1'b1;
        strobe.slot  = cfgAddr;
      end else if (int'(cfgAddr) < NOUT + OPS) begin
        strobe.wrOp = 1'b1;
        strobe.slot = cfgAddr - ADDR_W'(NOUT);
      end
    end
  end
endmodule

// File: rtl/tsb_datapath.sv
module tsb_datapath
  import tsb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  cfgStrobe_t              strobe,
  input  logic [NOUT*WIDTH-1:0]   inTracks,
  input  logic [WIDTH-1:0]        coreOut,
  output logic [NOUT*WIDTH-1:0]   outTracks,
  output logic [OPS*WIDTH-1:0]    coreOps,
  output logic [NOUT*SEL_W-1:0]   selView,
  output logic [NOUT-1:0]         regView,
  output logic [OPS*SEL_W-1:0]    opView
);
  for (genvar o = 0; o < NOUT; o++) begin : g_out
    localparam int MY_SIDE = o / TRACKS;
    sel_t             selQ;
    logic             regQ;
    logic [WIDTH-1:0] pick;
    logic [WIDTH-1:0] pipeQ;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        selQ <= '0;
        regQ <= 1'b0;
      end else if (strobe.wrOut && strobe.slot == ADDR_W'(o)) begin
        selQ <= strobe.sel;
        regQ <= strobe.regEn;
      end
    end

    // source pick: other-side input, core word, or zero
    always_comb begin
      pick = '0;
      if (selQ != '0 && int'(selQ) <= NOUT) begin
        if ((int'(selQ) - 1) / TRACKS != MY_SIDE)
          pick = inTracks[(int'(selQ) - 1)*WIDTH +: WIDTH];
      end else if (int'(selQ) == CORE_CODE) begin
        pick = coreOut;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pipeQ <= '0;
      else        pipeQ <= pick;
    end

    assign outTracks[o*WIDTH +: WIDTH] = regQ ? pipeQ : pick;
    assign selView[o*SEL_W +: SEL_W]   = selQ;
    assign regView[o]                  = regQ;
  end

  for (genvar k = 0; k < OPS; k++) begin : g_op
    sel_t             opQ;
    logic [WIDTH-1:0] tap;

    always_ff @(posedge clk) begin
      if (!rst_n)
        opQ <= '0;
      else if (strobe.wrOp && strobe.slot == ADDR_W'(k))
        opQ <= strobe.sel;
    end

    always_comb begin
      tap = '0;
      if (opQ != '0 && int'(opQ) <= NOUT)
        tap = outTracks[(int'(opQ) - 1)*WIDTH +: WIDTH];
    end

    assign coreOps[k*WIDTH +: WIDTH] = tap;
    assign opView[k*SEL_W +: SEL_W]  = opQ;
  end
endmodule

// File: rtl/track_switch_box.sv
module track_switch_box
  import tsb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfgWe,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [CFG_W-1:0]      cfgData,
  input  logic [NOUT*WIDTH-1:0] inTracks,
  input  logic [WIDTH-1:0]      coreOut,
  output logic [NOUT*WIDTH-1:0] outTracks,
  output logic [OPS*WIDTH-1:0]  coreOps
);
  cfgStrobe_t              strobe;
  logic [NOUT*SEL_W-1:0]   selView;
  logic [NOUT-1:0]         regView;
  logic [OPS*SEL_W-1:0]    opView;

  tsb_ctrl u_ctrl (
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .strobe  (strobe)
  );

  tsb_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .inTracks  (inTracks),
    .coreOut   (coreOut),
    .outTracks (outTracks),
    .coreOps   (coreOps),
    .selView   (selView),
    .regView   (regView),
    .opView    (opView)
  );
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker
  import tsb_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NOUT*WIDTH-1:0] inTracks,
  input logic [WIDTH-1:0]      coreOut,
  input logic [NOUT*WIDTH-1:0] outTracks,
  input logic [OPS*WIDTH-1:0]  coreOps,
  input logic [NOUT*SEL_W-1:0] selView,
  input logic [NOUT-1:0]       regView,
  input logic [OPS*SEL_W-1:0]  opView
);
  assert_reset_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (outTracks == '0 && coreOps == '0));

  for (genvar o = 0; o < NOUT; o++) begin : g_chk
    logic [SEL_W-1:0] s;
    logic [WIDTH-1:0] y;
    assign s = selView[o*SEL_W +: SEL_W];
    assign y = outTracks[o*WIDTH +: WIDTH];

    assert_other_side_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!regView[o] && s != '0 && int'(s) <= NOUT && (int'(s) - 1) / TRACKS != o / TRACKS)
      |-> y == inTracks[(int'(s) - 1)*WIDTH +: WIDTH]);

    assert_same_side_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!regView[o] && s != '0 && int'(s) <= NOUT && (int'(s) - 1) / TRACKS == o / TRACKS)
      |-> y == '0);

    assert_core_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!regView[o] && int'(s) == CORE_CODE) |-> y == coreOut);

    assert_reg_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (regView[o] && $past(regView[o]) && int'(s) == CORE_CODE && $past(s) == s)
      |-> y == $past(coreOut));
  end

  for (genvar k = 0; k < OPS; k++) begin : g_opchk
    logic [SEL_W-1:0] t;
    assign t = opView[k*SEL_W +: SEL_W];

    assert_operand_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (t != '0 && int'(t) <= NOUT)
      |-> coreOps[k*WIDTH +: WIDTH] == outTracks[(int'(t) - 1)*WIDTH +: WIDTH]);

    assert_operand_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (t == '0 || int'(t) > NOUT) |-> coreOps[k*WIDTH +: WIDTH] == '0);
  end
endmodule

bind track_switch_box tsb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inTracks  (inTracks),
  .coreOut   (coreOut),
  .outTracks (outTracks),
  .coreOps   (coreOps),
  .selView   (selView),
  .regView   (regView),
  .opView    (opView)
);

// File: tb/track_switch_box_bench.sv
`timescale 1ns/1ps
module track_switch_box_bench;
  import tsb_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  cfgWe = 1'b0;
  logic [ADDR_W-1:0]     cfgAddr = '0;
  logic [CFG_W-1:0]      cfgData = '0;
  logic [NOUT*WIDTH-1:0] inTracks = '0;
  logic [WIDTH-1:0]      coreOut = '0;
  logic [NOUT*WIDTH-1:0] outTracks;
  logic [OPS*WIDTH-1:0]  coreOps;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int               selM  [NOUT];
  int               regM  [NOUT];
  int               opM   [OPS];
  logic [WIDTH-1:0] pipeM [NOUT];

  always #2 clk = ~clk;

  track_switch_box u_track_switch_box (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .inTracks(inTracks), .coreOut(coreOut),
    .outTracks(outTracks), .coreOps(coreOps)
  );

  function automatic logic [WIDTH-1:0] srcVal(int o);
    int c = selM[o];
    if (c >= 1 && c <= NOUT) begin
      if ((c - 1) / TRACKS != o / TRACKS) return inTracks[(c-1)*WIDTH +: WIDTH];
      return '0;
    end
    if (c == CORE_CODE) return coreOut;
    return '0;
  endfunction

  function automatic logic [WIDTH-1:0] expOut(int o);
    return (regM[o] != 0) ? pipeM[o] : srcVal(o);
  endfunction

  task automatic compare(input string tag);
    logic [NOUT*WIDTH-1:0] ev;
    logic [OPS*WIDTH-1:0]  eo;
    for (int o = 0; o < NOUT; o++) ev[o*WIDTH +: WIDTH] = expOut(o);
    for (int k = 0; k < OPS; k++) begin
      if (opM[k] >= 1 && opM[k] <= NOUT) eo[k*WIDTH +: WIDTH] = expOut(opM[k] - 1);
      else eo[k*WIDTH +: WIDTH] = '0;
    end
    total++;
    if (outTracks !== ev) begin
      bad++;
      $display("FAIL %s outTracks got=%h exp=%h", tag, outTracks, ev);
    end
    total++;
    if (coreOps !== eo) begin
      bad++;
      $display("FAIL %s coreOps got=%h exp=%h", tag, coreOps, eo);
    end
  endtask

  task automatic modelEdge();
    logic [WIDTH-1:0] np [NOUT];
    for (int o = 0; o < NOUT; o++) np[o] = srcVal(o);
    if (!rst_n) begin
      for (int o = 0; o < NOUT; o++) begin
        selM[o] = 0; regM[o] = 0; pipeM[o] = '0;
      end
      for (int k = 0; k < OPS; k++) opM[k] = 0;
    end else begin
      for (int o = 0; o < NOUT; o++) pipeM[o] = np[o];
      if (cfgWe) begin
        if (int'(cfgAddr) < NOUT) begin
          selM[cfgAddr] = int'(cfgData[SEL_W-1:0]);
          regM[cfgAddr] = int'(cfgData[CFG_W-1]);
        end else if (int'(cfgAddr) < NOUT + OPS) begin
          opM[int'(cfgAddr) - NOUT] = int'(cfgData[SEL_W-1:0]);
        end
      end
    end
  endtask

  task automatic tick(input string tag, input bit doCheck);
    @(negedge clk);
    for (int i = 0; i < NOUT; i++) inTracks[i*WIDTH +: WIDTH] = WIDTH'($urandom);
    coreOut = WIDTH'($urandom);
    #1;
    if (doCheck) compare(tag);
    @(posedge clk);
    modelEdge();
    #1;
  endtask

  task automatic cfgWrite(input int addr, input int data, input string tag);
    cfgWe = 1'b1;
    cfgAddr = ADDR_W'(addr);
    cfgData = CFG_W'(data);
    tick(tag, 1'b1);
    cfgWe = 1'b0;
  endtask

  function automatic string tagOf(int o, int code, int r);
    if (r != 0) return "R4";
    if (code >= 1 && code <= NOUT)
      return ((code - 1) / TRACKS == o / TRACKS) ? "R2" : "R1";
    return "R3";
  endfunction

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog all-requirements got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int o = 0; o < NOUT; o++) begin
      selM[o] = 0; regM[o] = 0; pipeM[o] = '0;
    end
    for (int k = 0; k < OPS; k++) opM[k] = 0;

    for (int i = 0; i < 3; i++) tick("R7", 1'b0);
    rst_n = 1'b1;
    tick("R7", 1'b1);
    tick("R7", 1'b1);

    // R7: pipeline starts at zero when register bit turned on with no source
    cfgWrite(0, 32, "R7");
    tick("R7", 1'b1);
    cfgWrite(0, 0, "R8");

    // sweep every code on every output, unregistered then registered
    for (int o = 0; o < NOUT; o++) begin
      cfgWrite(NOUT, o + 1, "R6");
      for (int code = 0; code < 32; code++) begin
        cfgWrite(o, code, tagOf(o, code, 0));
        tick(tagOf(o, code, 0), 1'b1);
        tick(tagOf(o, code, 0), 1'b1);
        cfgWrite(o, 32 + code, "R8");
        tick(tagOf(o, code, 1), 1'b1);
        tick(tagOf(o, code, 1), 1'b1);
      end
      cfgWrite(o, 0, "R8");
    end

    // R5: branch of incoming track 0 (east) onto south, west, north outputs
    cfgWrite(4, 1, "R5");
    cfgWrite(8, 1, "R5");
    cfgWrite(13, 1, "R5");
    cfgWrite(1, 1, "R2");
    cfgWrite(12, 32 + 1, "R5");
    for (int i = 0; i < 6; i++) tick("R5", 1'b1);

    // R6: operand selector 1 over all codes, register bit set and ignored
    for (int code = 0; code < 32; code++) begin
      cfgWrite(NOUT + 1, 32 + code, "R6");
      tick("R6", 1'b1);
      tick("R6", 1'b1);
    end

    // R8: writes beyond the last entry have no effect
    for (int a = NOUT + OPS; a < 32; a++) begin
      cfgWrite(a, int'($urandom_range(0, 63)), "R8");
      tick("R8", 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule